// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Order

This block produces the internal access address for a synchronous memory that supports four-beat bursts. On each enabled clock edge, one control pin decides between two actions. When it is low, a fresh base address is captured from the address bus. When it is high, the burst moves to its next beat. A burst covers only the two lowest address bits; the upper bits keep the value they had at load for the whole burst.

A static strap input picks the beat order. Held high, it selects interleaved order, where the low bits are the start bits XORed with the beat count. Driven low, it selects linear order, where the beat count is added to the start bits modulo four. A board normally ties the strap high, so interleaved order is the usual configuration. The strap must not change while the block is in operation.

An active-low clock enable freezes all state when it is high. A deselected cycle marks the address invalid. Advance requests are then ignored until a new load arrives. The block reports the current address, a valid flag, the beat position and a last-beat flag.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_vld` is 0, `beat` is 0, `addr` is all zeros and `burst_last` is 0.
- R2: At an edge with `clk_en_n`=0, `sel`=1 and `adv`=0, the block loads a new address. From the next cycle, `addr` equals the sampled `base_addr`, `beat` is 0 and `addr_vld` is 1.
- R3: At an edge with `clk_en_n`=0, `sel`=1, `adv`=1 and `addr_vld`=1, `beat` increments by 1 modulo 4. The bits `addr[AW-1:2]` do not change.
- R4: With `ilv_mode`=0 (linear order), `addr[1:0]` equals (start low bits + `beat`) mod 4.
- R5: With `ilv_mode`=1 (interleaved order), `addr[1:0]` equals the start low bits XOR `beat`.
- R6: While `clk_en_n`=1 at an edge, `addr`, `beat` and `addr_vld` all keep their values, whatever the other inputs are.
- R7: At an edge with `clk_en_n`=0 and `sel`=0, `addr_vld` clears to 0, and `addr` and `beat` keep their values.
- R8: An advance request at an edge where `addr_vld` is 0 has no effect. `addr_vld` stays 0, and `addr` and `beat` are unchanged.
- R9: An advance after beat 3 wraps `beat` to 0, so `addr` returns to the loaded base. `burst_last` is 1 exactly when `addr_vld`=1 and `beat`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; when high, all state is frozen |
| sel | input | 1 | Device selected, active high |
| adv | input | 1 | 1 = advance the burst, 0 = load `base_addr` |
| ilv_mode | input | 1 | Order strap: 1 = interleaved, 0 = linear; static during operation |
| base_addr | input | AW | Address captured on a load |
| addr | output | AW | Current access address |
| addr_vld | output | 1 | The current address is valid |
| beat | output | 2 | Position within the burst, 0 to 3 |
| burst_last | output | 1 | Valid address at beat 3 |

## Verification
The bench drives bursts in both orders from start low bits of 1, 2 and 3. A wrong order formula shows up as a wrong low-bit sequence, and a carry leaking into the upper bits changes `addr[AW-1:2]`. Full bursts continue past the fourth beat, so a design that saturates instead of wrapping to the base address is caught. The bench raises the clock enable in the middle of a burst, and a design that ignores the enable would step the burst anyway. It also sends advances after a deselect and right after reset; a design that acts on them would raise `addr_vld` or move `beat`.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_n,
  input  logic          sel,
  input  logic          adv,
  input  logic          ilv_mode,
  input  logic [AW-1:0] base_addr,
  output logic [AW-1:0] addr,
  output logic          addr_vld,
  output logic [1:0]    beat,
  output logic          burst_last
);

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic          vld_q;
  logic [1:0]    low_bits;

  wire fire  = !clk_en_n;
  wire load  = fire && sel && !adv;
  wire step  = fire && sel && adv && vld_q;
  wire desel = fire && !sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      vld_q  <= 1'b0;
    end else if (load) begin
      base_q <= base_addr;
      cnt_q  <= 2'd0;
      vld_q  <= 1'b1;
    end else if (step) begin
      cnt_q  <= cnt_q + 2'd1;
    end else if (desel) begin
      vld_q  <= 1'b0;
    end
  end

  assign low_bits   = ilv_mode ? (base_q[1:0] ^ cnt_q) : (base_q[1:0] + cnt_q);
  assign addr       = {base_q[AW-1:2], low_bits};
  assign addr_vld   = vld_q;
  assign beat       = cnt_q;
  assign burst_last = vld_q && (cnt_q == 2'd3);

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          sel,
  input logic          adv,
  input logic          ilv_mode,
  input logic [AW-1:0] base_addr,
  input logic [AW-1:0] addr,
  input logic          addr_vld,
  input logic [1:0]    beat,
  input logic          burst_last
);

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && sel && !adv) |=> (addr_vld && beat == 2'd0 && addr == $past(base_addr)));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && sel && adv && addr_vld) |=>
      (beat == 2'($past(beat) + 2'd1) && addr[AW-1:2] == $past(addr[AW-1:2])));

  a_r4_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && sel && adv && addr_vld && !ilv_mode) |=>
      (addr[1:0] == 2'($past(addr[1:0]) + 2'd1)));

  a_r5_interleave: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && sel && adv && addr_vld && ilv_mode) |=>
      ((addr[1:0] ^ beat) == $past(addr[1:0] ^ beat)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(addr) && $stable(beat) && $stable(addr_vld)));

  a_r7_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !sel) |=> (!addr_vld && $stable(addr) && $stable(beat)));

  a_r8_no_stray_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && sel && adv && !addr_vld) |=> (!addr_vld && $stable(beat) && $stable(addr)));

  a_r9_last_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    burst_last |-> addr_vld);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en_n = 1'b1;
  logic          sel = 1'b0;
  logic          adv = 1'b0;
  logic          ilv_mode = 1'b1;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] addr;
  logic          addr_vld;
  logic [1:0]    beat;
  logic          burst_last;

  burst_addr_seq #(.AW(AW)) u_dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [AW+3:0] exp_q[$];
  string         tag_q[$];

  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          m_vld;

  function automatic logic [AW+3:0] expect_now();
    logic [1:0] lo;
    lo = ilv_mode ? (m_base[1:0] ^ m_cnt) : 2'(m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo, m_vld, m_cnt, (m_vld && m_cnt == 2'd3)};
  endfunction

  task automatic cyc(input logic en_n, input logic s, input logic a,
                     input logic [AW-1:0] ba, input string tag);
    @(negedge clk);
    clk_en_n = en_n; sel = s; adv = a; base_addr = ba;
    if (!en_n) begin
      if (s && !a) begin m_base = ba; m_cnt = 2'd0; m_vld = 1'b1; end
      else if (s && a && m_vld) m_cnt = 2'(m_cnt + 2'd1);
      else if (!s) m_vld = 1'b0;
    end
    exp_q.push_back(expect_now());
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [AW+3:0] e, g;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      g = {addr, addr_vld, beat, burst_last};
      checks++;
      if (g !== e) begin
        fails++;
        $display("FAIL %s: got addr=%h vld=%b beat=%0d last=%b, expected addr=%h vld=%b beat=%0d last=%b",
                 t, g[AW+3:4], g[3], g[2:1], g[0], e[AW+3:4], e[3], e[2:1], e[0]);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; clk_en_n = 1'b1; sel = 1'b0; adv = 1'b0;
    m_base = '0; m_cnt = 2'd0; m_vld = 1'b0;
    @(negedge clk);
    checks++;
    if ({addr, addr_vld, beat, burst_last} !== '0) begin
      fails++;
      $display("FAIL R1: got addr=%h vld=%b beat=%0d last=%b, expected all zero",
               addr, addr_vld, beat, burst_last);
    end
    rst_n = 1'b1;
  endtask

  task automatic run_order(input string tg);
    cyc(1'b0, 1'b1, 1'b1, 16'h0000, "R8 advance before any load");
    cyc(1'b0, 1'b1, 1'b0, 16'hA5F1, {"R2 load ", tg});
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 1'b1, 16'h0, {"R3 R9 advance ", tg});
    cyc(1'b0, 1'b1, 1'b0, 16'h3C12, {"R2 reload ", tg});
    cyc(1'b0, 1'b1, 1'b1, 16'h0, {"R3 ", tg});
    cyc(1'b1, 1'b1, 1'b1, 16'h0, "R6 enable high holds");
    cyc(1'b1, 1'b1, 1'b0, 16'hFFFF, "R6 load masked");
    cyc(1'b1, 1'b0, 1'b1, 16'h0, "R6 deselect masked");
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b1, 16'h0, {"R3 R9 resume ", tg});
    cyc(1'b0, 1'b0, 1'b1, 16'h0, "R7 deselect");
    cyc(1'b0, 1'b1, 1'b1, 16'h0, "R8 advance after deselect");
    cyc(1'b0, 1'b1, 1'b1, 16'h0, "R8 advance after deselect");
    cyc(1'b0, 1'b1, 1'b0, 16'hFFF3, {"R2 load after deselect ", tg});
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1, 16'h0, {"R3 R9 top ", tg});
    cyc(1'b0, 1'b0, 1'b0, 16'h1234, "R7 deselect ignores load");
    cyc(1'b1, 1'b0, 1'b0, 16'h0, "R6 idle");
    @(posedge clk); @(posedge clk);
  endtask

  initial begin
    ilv_mode = 1'b1;
    do_reset();
    run_order("R5 interleaved");
    ilv_mode = 1'b0;
    do_reset();
    run_order("R4 linear");
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule